// File: doc/BRIEF.md
# Bidirectional Zero-Fill Word Shifter

This block moves an unsigned data word left or right by a variable number of bit positions. Positions that are vacated are filled with zeros, and bits pushed past either end of the word are lost. It is a purely combinational datapath element. It suits the shift unit of an execution pipeline or any address or field-alignment path that needs a shift whose direction is chosen at run time.

The word width is a power of two, and the shift amount is a binary field just wide enough to count from zero to one less than the width. Inside, the shift is split into a chain of stages, one per bit of the amount. Stage i either holds its input or moves it by 2^i places, in the direction given by the direction input. Each stage selects one of three sources per bit: the bit in the same place, the neighbour 2^i places lower, or the neighbour 2^i places higher. A neighbour that falls outside the word is a constant zero. A small decode of the stage's amount bit and the direction drives that selection.

Top module: `bidir_lshift`

## Requirements
- R1: When `amt` is zero, `dout` equals `din` for either value of `dir_left`.
- R2: When `dir_left` is 1, `dout` equals `din` shifted toward the MSB by `amt` places, with the low `amt` bits of `dout` equal to zero.
- R3: When `dir_left` is 0, `dout` equals `din` shifted toward the LSB by `amt` places, with the high `amt` bits of `dout` equal to zero.
- R4: Bits that leave the word at one end never re-enter at the other end: a shift by 4 of 0xF000000F gives 0x000000F0 leftward and 0x0F000000 rightward.
- R5: The total movement is the binary value of `amt`: each set bit i of `amt` contributes 2^i places, so an amount with several set bits (for example 21) moves the word by exactly that many places.
- R6: At the largest amount (width minus one), a left shift keeps only `din[0]`, which appears at the MSB, and a right shift keeps only the MSB of `din`, which appears at bit 0.
- R7: The block holds no state. `dout` follows a change of `din`, `amt` or `dir_left` with no clock edge between them, and a shift never produces more set bits than `din` has.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | W | Data word to be shifted |
| amt | input | AW = log2(W) | Shift distance in bit places |
| dir_left | input | 1 | 1 shifts toward the MSB, 0 shifts toward the LSB |
| dout | output | W | Shifted word with zero fill |

## Verification
The bench targets the edges where a shifter most often breaks. A design that wraps bits around would show up as ones in the zero-filled region in the R4 and R6 vectors, and so would any stage whose neighbour at the border of the word is not tied to zero. If one stage decodes the direction backwards, a multi-bit amount such as 21 moves part of the way each way, so the result is wrong even though single-bit amounts look fine. A walking single bit at every amount in both directions finds a stage that is wired to the wrong amount bit or that moves by the wrong power of two. The zero-amount cases with both directions find a decode that shifts when its enable is clear.

// File: rtl/bls_pkg.sv
package bls_pkg;

    // Per-stage source choice for every bit of the stage
    typedef enum logic [1:0] {
        PICK_HOLD  = 2'b00,   // keep bit j
        PICK_LOWER = 2'b01,   // take bit j - step (moves data toward MSB)
        PICK_UPPER = 2'b10    // take bit j + step (moves data toward LSB)
    } pick_e;

endpackage

// File: rtl/bls_pick_dec.sv
module bls_pick_dec
    import bls_pkg::*;
(
    input  logic  step_en,
    input  logic  go_left,
    output pick_e pick_d
);

    always_comb begin
        pick_d = PICK_HOLD;
        if (step_en) begin
            pick_d = go_left ? PICK_LOWER : PICK_UPPER;
        end
    end

endmodule

// File: rtl/bls_stage.sv
module bls_stage
    import bls_pkg::*;
#(
    parameter int W    = 32,
    parameter int STEP = 1
) (
    input  logic [W-1:0] stg_in,
    input  pick_e        pick,
    output logic [W-1:0] stg_out
);

    logic [W-1:0] from_lower_d;
    logic [W-1:0] from_upper_d;

    // Zero-padded neighbourhood: sources outside the word are constant zero
    for (genvar j = 0; j < W; j++) begin : g_bit
        if (j >= STEP) begin : g_lo_in
            assign from_lower_d[j] = stg_in[j-STEP];
        end else begin : g_lo_pad
            assign from_lower_d[j] = 1'b0;
        end
        if (j + STEP < W) begin : g_hi_in
            assign from_upper_d[j] = stg_in[j+STEP];
        end else begin : g_hi_pad
            assign from_upper_d[j] = 1'b0;
        end
    end

    always_comb begin
        unique case (pick)
            PICK_LOWER: stg_out = from_lower_d;
            PICK_UPPER: stg_out = from_upper_d;
            default:    stg_out = stg_in;
        endcase
    end

endmodule

// File: rtl/bidir_lshift.sv
module bidir_lshift
    import bls_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  logic          dir_left,
    output logic [W-1:0]  dout
);

    localparam int NSTG = AW;

    logic [W-1:0] chain_d [NSTG+1];
    pick_e        pick_d  [NSTG];

    assign chain_d[0] = din;

    // Stage i moves by 2^i places under control of amt[i]
    for (genvar i = 0; i < NSTG; i++) begin : g_stg
        bls_pick_dec u_dec (
            .step_en (amt[i]),
            .go_left (dir_left),
            .pick_d  (pick_d[i])
        );
        bls_stage #(
            .W    (W),
            .STEP (1 << i)
        ) u_stage (
            .stg_in  (chain_d[i]),
            .pick    (pick_d[i]),
            .stg_out (chain_d[i+1])
        );
    end

    assign dout = chain_d[NSTG];

endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input logic [W-1:0]  din,
    input logic [AW-1:0] amt,
    input logic          dir_left,
    input logic [W-1:0]  dout
);

    logic [W-1:0] low_fill;
    logic [W-1:0] high_fill;

    always_comb begin
        low_fill  = ~({W{1'b1}} << amt);
        high_fill = ~({W{1'b1}} >> amt);

        // R1
        zero_amt_chk: assert ((amt != '0) || (dout == din));
        // R2
        left_fill_chk: assert (!dir_left || ((dout & low_fill) == '0));
        // R2
        left_value_chk: assert (!dir_left || (dout == (din << amt)));
        // R3
        right_fill_chk: assert (dir_left || ((dout & high_fill) == '0));
        // R3
        right_value_chk: assert (dir_left || (dout == (din >> amt)));
        // R7
        no_new_ones_chk: assert ($countones(dout) <= $countones(din));
    end

endmodule

bind bidir_lshift bls_checker #(
    .W  (W),
    .AW (AW)
) u_chk (
    .din      (din),
    .amt      (amt),
    .dir_left (dir_left),
    .dout     (dout)
);

// File: tb/bidir_lshift_tb.sv
module bidir_lshift_tb;

    localparam int W  = 32;
    localparam int AW = 5;
    localparam int NV = 14;

    logic          clk = 1'b0;
    logic [W-1:0]  din;
    logic [AW-1:0] amt;
    logic          dir_left;
    logic [W-1:0]  dout;

    int total = 0;
    int bad   = 0;
    int ticks = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bidir_lshift #(.W(W), .AW(AW)) u_dut (
        .din      (din),
        .amt      (amt),
        .dir_left (dir_left),
        .dout     (dout)
    );

    // entry: {din, amt, dir_left, expected}
    localparam logic [69:0] VEC [NV] = '{
        {32'h0000_0002, 5'd2,  1'b1, 32'h0000_0008},  // R2
        {32'h0000_0002, 5'd2,  1'b0, 32'h0000_0000},  // R3
        {32'hF000_000F, 5'd4,  1'b1, 32'h0000_00F0},  // R4
        {32'hF000_000F, 5'd4,  1'b0, 32'h0F00_0000},  // R4
        {32'h1234_5678, 5'd0,  1'b1, 32'h1234_5678},  // R1
        {32'h1234_5678, 5'd0,  1'b0, 32'h1234_5678},  // R1
        {32'h8000_0001, 5'd31, 1'b1, 32'h8000_0000},  // R6
        {32'h8000_0001, 5'd31, 1'b0, 32'h0000_0001},  // R6
        {32'hDEAD_BEEF, 5'd8,  1'b1, 32'hADBE_EF00},  // R2
        {32'hDEAD_BEEF, 5'd8,  1'b0, 32'h00DE_ADBE},  // R3
        {32'hDEAD_BEEF, 5'd21, 1'b0, 32'h0000_06F5},  // R5
        {32'hDEAD_BEEF, 5'd21, 1'b1, 32'hDDE0_0000},  // R5
        {32'hA5A5_A5A5, 5'd1,  1'b1, 32'h4B4B_4B4A},  // R2
        {32'hA5A5_A5A5, 5'd1,  1'b0, 32'h52D2_D2D2}   // R3
    };

    localparam string VTAG [NV] = '{
        "R2", "R3", "R4", "R4", "R1", "R1", "R6", "R6",
        "R2", "R3", "R5", "R5", "R2", "R3"
    };

    task automatic check(input string tag, input logic [W-1:0] got,
                         input logic [W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h exp=%h (din=%h amt=%0d left=%0b)",
                     tag, got, exp, din, amt, dir_left);
        end
    endtask

    task automatic apply(input logic [W-1:0] d, input logic [AW-1:0] a,
                         input logic l);
        @(negedge clk);
        din      = d;
        amt      = a;
        dir_left = l;
        #1;
    endtask

    always @(posedge clk) begin
        ticks <= ticks + 1;
        if (!done && ticks > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout exp=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        din = '0; amt = '0; dir_left = 1'b0;
        #1;
        // idle state with all-zero inputs: R1
        check("R1", dout, 32'h0);

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][69:38], VEC[v][37:33], VEC[v][32]);
            check(VTAG[v], dout, VEC[v][31:0]);
        end

        // R2 / R3: walking single bit at every amount, both directions
        for (int a = 0; a < W; a++) begin
            apply(32'h0000_0001, AW'(a), 1'b1);
            check("R2", dout, 32'h0000_0001 << a);
            apply(32'h8000_0000, AW'(a), 1'b0);
            check("R3", dout, 32'h8000_0000 >> a);
        end

        // R7: output follows an input change with no clock edge in between
        @(negedge clk);
        din = 32'h0000_00FF; amt = 5'd4; dir_left = 1'b1;
        #0.5;
        check("R7", dout, 32'h0000_0FF0);
        dir_left = 1'b0;
        #0.5;
        check("R7", dout, 32'h0000_000F);
        amt = 5'd0;
        #0.5;
        check("R7", dout, 32'h0000_00FF);

        // R6: all ones at maximum amount
        apply(32'hFFFF_FFFF, 5'd31, 1'b1);
        check("R6", dout, 32'h8000_0000);
        apply(32'hFFFF_FFFF, 5'd31, 1'b0);
        check("R6", dout, 32'h0000_0001);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule